// File: doc/BRIEF.md
# Banked Multi-CPU Doorbell Interrupt Controller

This controller lets any of up to four processors raise software doorbell interrupts on any chosen group of processors. Every processor owns a bank of registers: a set of pending doorbells, a per-doorbell enable mask, a summary mask that gates the doorbell interrupt as a whole, and an acknowledge register that reports whether a doorbell interrupt is waiting. A single trigger register is shared by all processors. One write to it names a doorbell and a bitmap of target processors, and that doorbell becomes pending on each target.

All accesses arrive on one shared single-cycle register port that carries the accessing processor's id as a sideband. The lower half of the address space is an alias window: the same offsets reach the bank of whichever processor makes the access. The upper half, selected by address bit 11, always reaches processor 0's bank, whatever the sideband says. Each processor gets a level interrupt output that stays high while it has an enabled pending doorbell and its summary is unmasked.

Top module: `db_doorbell_ctrl`

## Requirements
- R1: After reset every bank has no pending doorbells, every doorbell disabled and the summary masked; all interrupt outputs are low and the acknowledge register reads 1023.
- R2: A write to offset 0x004 (either window) sets doorbell number wdata[2:0] pending on every processor k with wdata[8+k] = 1, from the next cycle; bitmap bits 12 to 15 and processors not named are left unchanged.
- R3: The pending register at offset 0x008 reads the bank's pending doorbells in bits [7:0]; a write keeps the pending bits where wdata is 1 and clears those where it is 0, so writing zero clears them all.
- R4: The enable mask at offset 0x00C is read and written in bits [7:0]; a 1 in bit n lets pending doorbell n raise the interrupt.
- R5: Reading offset 0x044 returns 0 in bits [9:0] when an enabled doorbell is pending and the summary is unmasked, and 1023 otherwise; the read changes no state.
- R6: Writing 0 in bits [9:0] to offset 0x048 masks the bank's summary, and writing 0 in bits [9:0] to offset 0x04C unmasks it; writes with any other identifier leave the summary as it is. Both offsets read as zero.
- R7: Interrupt output k is high exactly while bank k has a pending and enabled doorbell and its summary is unmasked, following each register write from the next cycle.
- R8: With address bit 11 clear, per-processor offsets reach the bank of the processor named by bus_cpu; with bit 11 set they reach processor 0's bank for any bus_cpu.
- R9: Offsets other than those listed read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_cpu | input | 2 | Id of the processor making the access |
| bus_addr | input | 12 | Byte address; bit 11 selects the fixed processor-0 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_out | output | 4 | Level doorbell interrupt, one per processor |

## Verification
The assertions assume a single access per cycle on the shared port, a bus_cpu value below the processor count, and a reset held from time zero through at least one clock edge. The trigger check further assumes the doorbell number is within the implemented range, which holds for the default eight doorbells since the field is three bits wide. The stimulus drives one access per cycle from a seeded random mix of every register, both windows and all processor ids, with data biased toward zero on the pending and summary registers so that clears and unmasks happen often, and it holds reset high from the start.

// File: rtl/db_pkg.sv
package db_pkg;

    // Register offsets inside a window (window base set by address bit 11)
    localparam logic [10:0] OFS_TRIG  = 11'h004;
    localparam logic [10:0] OFS_CAUSE = 11'h008;
    localparam logic [10:0] OFS_MASK  = 11'h00C;
    localparam logic [10:0] OFS_ACK   = 11'h044;
    localparam logic [10:0] OFS_SMSET = 11'h048;
    localparam logic [10:0] OFS_SMCLR = 11'h04C;

    // Doorbell field positions inside the trigger word
    localparam int TGT_LSB = 8;

    // Widest supported doorbell set and identifier codes
    localparam int MAX_DB = 8;
    localparam logic [9:0] ID_DOORBELL = 10'd0;
    localparam logic [9:0] ID_NONE     = 10'd1023;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_TRIG,
        RK_CAUSE,
        RK_MASK,
        RK_ACK,
        RK_SMSET,
        RK_SMCLR
    } db_reg_e;

    typedef struct packed {
        logic    we;
        db_reg_e kind;
    } db_access_t;

    typedef struct packed {
        logic [MAX_DB-1:0] cause;
        logic [MAX_DB-1:0] mask;
        logic [9:0]        ack_id;
    } db_view_t;

    function automatic db_reg_e decode_ofs(input logic [10:0] ofs);
        db_reg_e k;
        case (ofs)
            OFS_TRIG:  k = RK_TRIG;
            OFS_CAUSE: k = RK_CAUSE;
            OFS_MASK:  k = RK_MASK;
            OFS_ACK:   k = RK_ACK;
            OFS_SMSET: k = RK_SMSET;
            OFS_SMCLR: k = RK_SMCLR;
            default:   k = RK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode
    import db_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               we,
    input  logic [CPU_W-1:0]   cpu,
    input  logic [11:0]        addr,
    output db_access_t         acc,
    output logic [NUM_CPU-1:0] bank_sel
);

    logic fixed_win;
    logic per_cpu;

    assign fixed_win = addr[11];

    always_comb begin
        acc.we   = we;
        acc.kind = en ? decode_ofs(addr[10:0]) : RK_NONE;
    end

    assign per_cpu = (acc.kind != RK_NONE) && (acc.kind != RK_TRIG);

    always_comb begin
        bank_sel = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (per_cpu) begin
                if (fixed_win) bank_sel[i] = (i == 0);
                else           bank_sel[i] = (int'(cpu) == i);
            end
        end
    end

    // R8
    fixed_window_chk: assert property (@(posedge clk) disable iff (rst)
        (en && addr[11]) |-> ((bank_sel >> 1) == '0));

    // R8
    alias_window_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !addr[11] && (acc.kind == RK_CAUSE) && (int'(cpu) < NUM_CPU))
        |-> bank_sel[cpu]);

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
#(
    parameter int NUM_DB = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  db_access_t       acc,
    input  logic [31:0]      wdata,
    input  logic             trig_hit,
    input  logic [IDX_W-1:0] trig_idx,
    output db_view_t         view,
    output logic             irq
);

    logic [NUM_DB-1:0] cause_q;
    logic [NUM_DB-1:0] mask_q;
    logic              sum_en_q;
    logic [NUM_DB-1:0] keep_bits;
    logic [NUM_DB-1:0] set_bits;
    logic              wr;
    logic              id_zero;
    logic              pending;

    assign wr      = sel && acc.we;
    assign id_zero = (wdata[9:0] == ID_DOORBELL);

    always_comb begin
        keep_bits = '1;
        if (wr && acc.kind == RK_CAUSE) keep_bits = wdata[NUM_DB-1:0];
        set_bits = trig_hit ? (NUM_DB'(1) << trig_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q  <= '0;
            mask_q   <= '0;
            sum_en_q <= 1'b0;
        end else begin
            // a trigger landing with a clear keeps its doorbell
            cause_q <= (cause_q & keep_bits) | set_bits;
            if (wr && acc.kind == RK_MASK) mask_q <= wdata[NUM_DB-1:0];
            if (wr && id_zero && acc.kind == RK_SMSET) sum_en_q <= 1'b0;
            if (wr && id_zero && acc.kind == RK_SMCLR) sum_en_q <= 1'b1;
        end
    end

    assign pending = (|(cause_q & mask_q)) && sum_en_q;
    assign irq     = pending;

    always_comb begin
        view.cause  = MAX_DB'(cause_q);
        view.mask   = MAX_DB'(mask_q);
        view.ack_id = pending ? ID_DOORBELL : ID_NONE;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cause_q == '0 && mask_q == '0 && !sum_en_q));

    // R2
    trig_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && (int'(trig_idx) < NUM_DB)) |=> cause_q[$past(trig_idx)]);

    // R3
    cause_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.kind == RK_CAUSE && wdata[NUM_DB-1:0] == '0 && !trig_hit)
        |=> (cause_q == '0));

    // R6
    summary_unmask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.kind == RK_SMCLR && id_zero) |=> sum_en_q);

    // R6
    summary_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.kind == RK_SMSET && id_zero) |=> !irq);

endmodule

// File: rtl/db_doorbell_ctrl.sv
module db_doorbell_ctrl
    import db_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_DB  = 8,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W  = (NUM_DB > 1) ? $clog2(NUM_DB) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] irq_out
);

    db_access_t         acc;
    logic [NUM_CPU-1:0] bank_sel;
    logic               trig_fire;
    logic [IDX_W-1:0]   trig_idx;
    db_view_t           bank_view [NUM_CPU];
    db_view_t           view_sel;

    db_addr_decode #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) i_decode (
        .clk      (clk),
        .rst      (rst),
        .en       (bus_en),
        .we       (bus_we),
        .cpu      (bus_cpu),
        .addr     (bus_addr),
        .acc      (acc),
        .bank_sel (bank_sel)
    );

    assign trig_fire = acc.we && (acc.kind == RK_TRIG);
    assign trig_idx  = bus_wdata[IDX_W-1:0];

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_bank
        db_cpu_bank #(
            .NUM_DB (NUM_DB),
            .IDX_W  (IDX_W)
        ) i_bank (
            .clk      (clk),
            .rst      (rst),
            .sel      (bank_sel[g]),
            .acc      (acc),
            .wdata    (bus_wdata),
            .trig_hit (trig_fire && bus_wdata[TGT_LSB + g]),
            .trig_idx (trig_idx),
            .view     (bank_view[g]),
            .irq      (irq_out[g])
        );
    end

    always_comb begin
        view_sel = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (bank_sel[i]) view_sel = bank_view[i];
        end
        bus_rdata = '0;
        if (!acc.we) begin
            case (acc.kind)
                RK_CAUSE: bus_rdata = 32'(view_sel.cause);
                RK_MASK:  bus_rdata = 32'(view_sel.mask);
                RK_ACK:   bus_rdata = 32'(view_sel.ack_id);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R5
    ack_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && acc.kind == RK_ACK && |(bank_sel & irq_out))
        |-> (bus_rdata[9:0] == ID_DOORBELL));

    // R5
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && acc.kind == RK_ACK && (bank_sel & irq_out) == '0
         && bank_sel != '0)
        |-> (bus_rdata[9:0] == ID_NONE));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && acc.kind == RK_NONE) |-> (bus_rdata == '0));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_en && !$past(bus_en)) |-> $stable(irq_out));

endmodule

// File: tb/test_db_doorbell_ctrl.sv
module test_db_doorbell_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [ND-1:0] m_cause [NC];
    logic [ND-1:0] m_mask  [NC];
    logic          m_en    [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    db_doorbell_ctrl i_db_doorbell_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq(input int k);
        return (|(m_cause[k] & m_mask[k])) && m_en[k];
    endfunction

    function automatic int bank_of(input logic [1:0] cpu, input logic [11:0] addr);
        return addr[11] ? 0 : int'(cpu);
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] cpu, input logic [11:0] addr);
        int b;
        b = bank_of(cpu, addr);
        case (addr[10:0])
            11'h008: return 32'(m_cause[b]);
            11'h00C: return 32'(m_mask[b]);
            11'h044: return exp_irq(b) ? 32'd0 : 32'd1023;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] addr);
        case (addr[10:0])
            11'h008: return "R3";
            11'h00C: return "R4";
            11'h044: return "R5";
            11'h048, 11'h04C: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_write(input logic [1:0] cpu, input logic [11:0] addr,
                               input logic [31:0] d);
        int b;
        b = bank_of(cpu, addr);
        case (addr[10:0])
            11'h004: for (int k = 0; k < NC; k++) if (d[8+k]) m_cause[k][d[2:0]] = 1'b1;
            11'h008: m_cause[b] = m_cause[b] & d[ND-1:0];
            11'h00C: m_mask[b] = d[ND-1:0];
            11'h048: if (d[9:0] == 10'd0) m_en[b] = 1'b0;
            11'h04C: if (d[9:0] == 10'd0) m_en[b] = 1'b1;
            default: ;
        endcase
    endtask

    // One access per cycle; irq checked before each access (R7)
    task automatic do_op(input logic [1:0] cpu, input logic we, input logic [11:0] addr,
                         input logic [31:0] d, input string req);
        string r;
        @(negedge clk);
        for (int k = 0; k < NC; k++)
            check(irq_out[k] == exp_irq(k), "R7", 32'(irq_out[k]), 32'(exp_irq(k)));
        bus_en = 1'b1; bus_we = we; bus_cpu = cpu; bus_addr = addr; bus_wdata = d;
        #1;
        if (!we) begin
            r = (req == "") ? req_of(addr) : req;
            check(bus_rdata == exp_read(cpu, addr), r, bus_rdata, exp_read(cpu, addr));
        end
        @(posedge clk);
        if (we) model_write(cpu, addr, d);
        #1;
        bus_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [31:0] d;
        logic [1:0]  c;
        void'($urandom(32'd13579));
        for (int k = 0; k < NC; k++) begin
            m_cause[k] = '0; m_mask[k] = '0; m_en[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state of every bank
        for (int k = 0; k < NC; k++) begin
            do_op(2'(k), 1'b0, 12'h008, 0, "R1");
            do_op(2'(k), 1'b0, 12'h00C, 0, "R1");
            do_op(2'(k), 1'b0, 12'h044, 0, "R1");
        end

        // R2 trigger from cpu3 to cpu1, doorbell 4
        do_op(2'd1, 1'b1, 12'h00C, 32'hFF, "R4");
        do_op(2'd3, 1'b1, 12'h004, 32'h0000_0204, "R2");
        do_op(2'd1, 1'b0, 12'h008, 0, "R2");
        do_op(2'd0, 1'b0, 12'h008, 0, "R2");
        // R5 summary still masked
        do_op(2'd1, 1'b0, 12'h044, 0, "R5");
        // R6 unmask, ignored mask-set, real mask-set
        do_op(2'd1, 1'b1, 12'h04C, 32'd0, "R6");
        do_op(2'd1, 1'b0, 12'h044, 0, "R5");
        do_op(2'd1, 1'b1, 12'h048, 32'd5, "R6");
        do_op(2'd1, 1'b0, 12'h044, 0, "R6");
        do_op(2'd1, 1'b1, 12'h048, 32'd0, "R6");
        do_op(2'd1, 1'b0, 12'h044, 0, "R6");
        do_op(2'd1, 1'b0, 12'h048, 0, "R6");

        // R2 bitmap bits above the processor count are ignored
        do_op(2'd2, 1'b1, 12'h004, 32'h0000_F107, "R2");
        for (int k = 0; k < NC; k++) do_op(2'(k), 1'b0, 12'h008, 0, "R2");

        // R8 fixed window from cpu2 reaches cpu0
        do_op(2'd2, 1'b1, 12'h80C, 32'h3C, "R8");
        do_op(2'd0, 1'b0, 12'h00C, 0, "R8");
        do_op(2'd2, 1'b0, 12'h00C, 0, "R8");
        do_op(2'd3, 1'b0, 12'h808, 0, "R8");

        // R3 partial keep, then full clear
        do_op(2'd0, 1'b1, 12'h004, 32'h0000_0F03, "R2");
        do_op(2'd1, 1'b1, 12'h008, 32'h08, "R3");
        do_op(2'd1, 1'b0, 12'h008, 0, "R3");
        do_op(2'd1, 1'b1, 12'h008, 32'h00, "R3");
        do_op(2'd1, 1'b0, 12'h008, 0, "R3");

        // R9 unmapped write has no effect, reads zero
        do_op(2'd0, 1'b1, 12'h010, 32'hFFFF_FFFF, "R9");
        do_op(2'd0, 1'b0, 12'h010, 0, "R9");
        do_op(2'd0, 1'b0, 12'h008, 0, "R9");
        do_op(2'd0, 1'b0, 12'h00C, 0, "R9");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            c = 2'($urandom_range(0, NC-1));
            case ($urandom_range(0, 7))
                0: a = 12'h004;
                1: a = 12'h008;
                2: a = 12'h00C;
                3: a = 12'h044;
                4: a = 12'h048;
                5: a = 12'h04C;
                6: a = 12'h004;
                default: case ($urandom_range(0, 3))
                    0: a = 12'h000;
                    1: a = 12'h040;
                    2: a = 12'h050;
                    default: a = 12'h7FC;
                endcase
            endcase
            if ($urandom_range(0, 3) == 0) a[11] = 1'b1;
            d = $urandom();
            if (a[10:0] != 11'h004 && $urandom_range(0, 1) == 0) d = 32'd0;
            do_op(c, 1'($urandom_range(0, 1)), a, d, "");
        end

        @(negedge clk);
        for (int k = 0; k < NC; k++)
            check(irq_out[k] == exp_irq(k), "R7", 32'(irq_out[k]), 32'(exp_irq(k)));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule